// File: doc/BRIEF.md
# Byte-write, word-read dual-port memory

This block is a 256-byte synchronous memory with two independent sides. One side only writes: each enabled edge of the write clock stores one byte at a byte address. The other side only reads. A read can be either one byte wide or two bytes wide, chosen by parameter. In the two-byte form the read address is one bit narrower, and each read returns an aligned pair of stored bytes. Both sides may act in the same cycle.

The read path has two stages. The address is captured on a read-clock edge, and the fetched word is registered again before it reaches the output. Parameters choose one of two clocking schemes: the read side shares the write clock, or it runs from its own clock. They also choose whether a read enable is honoured, and what a read of the byte being written in the same edge returns. The contents start at zero without any reset or load step.

Top module: `mw_sdpram`

## Requirements
- R1: All 256 byte locations can be written; a byte is stored at `wr_addr` only on a rising `wr_clk` edge where `wr_en` is 1.
- R2: With RATIO=1, `rd_data` returns the byte stored at `rd_addr`.
- R3: With RATIO=2, read address A returns byte 2A on bits [7:0] and byte 2A+1 on bits [15:8]; A=127 reaches bytes 254 and 255.
- R4: Read data appears on `rd_data` after the second rising read-clock edge after the address is applied, and not after the first.
- R5: With HAS_RD_EN=1, an edge where `rd_en` is 0 captures nothing, so `rd_data` keeps its value once the pipeline has drained, whatever `rd_addr` does.
- R6: With one shared clock and RDW_OLD=1, a read and a write of the same byte on the same edge return the old contents; the new byte is returned by later reads.
- R7: Every location reads as zero before it is first written; no reset or load is needed.
- R8: Edges with `wr_en` at 0 leave memory unchanged, whatever `wr_addr` and `wr_data` carry.
- R9: With SEP_CLK=1 the read side runs from `rd_clk` alone, bytes written on `wr_clk` can be read on it, and with HAS_RD_EN=0 a read happens on every `rd_clk` edge even with `rd_en` held at 0.
- R10: A write to one address and a read of a different address on the same edge do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; also the read clock when SEP_CLK=0 |
| rd_clk | input | 1 | Read clock, used only when SEP_CLK=1 |
| wr_en | input | 1 | Store `wr_data` on this edge |
| wr_addr | input | AW (8) | Byte address of the write |
| wr_data | input | BW (8) | Byte to store |
| rd_en | input | 1 | Capture a new read address, used only when HAS_RD_EN=1 |
| rd_addr | input | RAW (8 or 7) | Word address of the read |
| rd_data | output | RDW (8 or 16) | Registered read word |

## Verification
A corrupted storage byte, a swapped lane or a wrong word-to-byte mapping shows up on `rd_data` two read edges after that location is addressed. Reading a run of consecutive addresses with distinct values exposes it at once. An extra or missing pipeline register shifts the whole stream by one edge, and a wrongly gated capture stage lets `rd_data` move while the read enable is low. The same-edge collision case shows whether the fetch happens before or after the store.

// File: rtl/mw_sdpram.sv
module mw_sdpram #(
  parameter int DEPTH = 256,
  parameter int BW = 8,
  parameter int RATIO = 1,
  parameter bit SEP_CLK = 1'b0,
  parameter bit HAS_RD_EN = 1'b1,
  parameter bit RDW_OLD = 1'b1,
  localparam int AW = $clog2(DEPTH),
  localparam int RAW = AW - $clog2(RATIO),
  localparam int RDW = BW * RATIO
) (
  input  logic           wr_clk,
  input  logic           rd_clk,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [BW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [RAW-1:0] rd_addr,
  output logic [RDW-1:0] rd_data
);

  logic [BW-1:0]  mem [DEPTH] = '{default: '0};
  logic [RDW-1:0] fetch;
  logic [RDW-1:0] out_q = '0;
  logic           rck;
  logic           rd_go;

  assign rck   = SEP_CLK ? rd_clk : wr_clk;
  assign rd_go = HAS_RD_EN ? rd_en : 1'b1;

  always_ff @(posedge wr_clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  for (genvar l = 0; l < RATIO; l++) begin : g_lane
    logic [AW-1:0] ba;
    logic [BW-1:0] lane_q = '0;
    assign ba = AW'(int'(rd_addr) * RATIO + l);
    if (RDW_OLD || SEP_CLK) begin : g_old
      always_ff @(posedge rck)
        if (rd_go) lane_q <= mem[ba];
    end else begin : g_fwd
      always_ff @(posedge rck)
        if (rd_go) lane_q <= (wr_en && wr_addr == ba) ? wr_data : mem[ba];
    end
    assign fetch[l*BW +: BW] = lane_q;
  end

  always_ff @(posedge rck)
    out_q <= fetch;

  assign rd_data = out_q;

endmodule

// File: rtl/mw_sdpram_chk.sv
module mw_sdpram_chk #(
  parameter int DEPTH = 256,
  parameter int BW = 8,
  parameter int RATIO = 1,
  parameter bit SEP_CLK = 1'b0,
  parameter bit HAS_RD_EN = 1'b1,
  parameter bit RDW_OLD = 1'b1,
  localparam int AW = $clog2(DEPTH),
  localparam int RAW = AW - $clog2(RATIO),
  localparam int RDW = BW * RATIO
) (
  input logic           wr_clk,
  input logic           rd_clk,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [BW-1:0]  wr_data,
  input logic           rd_en,
  input logic [RAW-1:0] rd_addr,
  input logic [RDW-1:0] rd_data
);
  logic       rck;
  logic       go;
  logic       touch;
  logic [2:0] warm = '0;
  logic       warm_ok;
  logic       any_wr = 1'b0;

  assign rck     = SEP_CLK ? rd_clk : wr_clk;
  assign go      = HAS_RD_EN ? rd_en : 1'b1;
  assign warm_ok = (warm == 3'd4);
  assign touch   = wr_en && (int'(wr_addr) / RATIO == int'(rd_addr));

  always_ff @(posedge rck) begin
    if (!warm_ok) warm <= warm + 3'd1;
    any_wr <= any_wr | wr_en;
  end

  a_r5_hold_when_disabled: assert property (@(posedge rck) disable iff (!warm_ok)
    (HAS_RD_EN && !$past(go, 2)) |-> $stable(rd_data));

  a_r7_blank_before_write: assert property (@(posedge rck) disable iff (!warm_ok)
    (!SEP_CLK && !$past(any_wr)) |-> (rd_data == '0));

  a_r4_repeat_read_stable: assert property (@(posedge rck) disable iff (!warm_ok)
    (!SEP_CLK && $past(go, 2) && $past(go, 3) && ($past(rd_addr, 2) == $past(rd_addr, 3))
     && !$past(wr_en, 2) && !$past(wr_en, 3)) |-> $stable(rd_data));

  a_r10_other_write_stable: assert property (@(posedge rck) disable iff (!warm_ok)
    (!SEP_CLK && $past(go, 2) && $past(go, 3) && ($past(rd_addr, 2) == $past(rd_addr, 3))
     && !$past(touch, 2) && !$past(touch, 3)) |-> $stable(rd_data));

  wire unused_ok = ^{wr_data, 1'b0};
endmodule

bind mw_sdpram mw_sdpram_chk #(
  .DEPTH(DEPTH), .BW(BW), .RATIO(RATIO),
  .SEP_CLK(SEP_CLK), .HAS_RD_EN(HAS_RD_EN), .RDW_OLD(RDW_OLD)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/mw_sdpram_bench.sv
module mw_sdpram_bench;
  localparam int CLK_NS  = 10;
  localparam int RCLK_NS = 14;

  logic        clk = 1'b0;
  logic        rclk = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b1;
  logic [7:0]  n_addr = '0;
  logic [6:0]  w_addr = '0;
  logic [7:0]  s_addr = '0;
  logic [7:0]  n_data;
  logic [15:0] w_data;
  logic [7:0]  s_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_NS/2) clk = ~clk;
  always #(RCLK_NS/2) rclk = ~rclk;

  mw_sdpram #(.RATIO(1), .SEP_CLK(1'b0), .HAS_RD_EN(1'b1), .RDW_OLD(1'b1)) u_mw_sdpram (
    .wr_clk(clk), .rd_clk(1'b0), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(n_addr), .rd_data(n_data));

  mw_sdpram #(.RATIO(2), .SEP_CLK(1'b0), .HAS_RD_EN(1'b1), .RDW_OLD(1'b1)) u_wide (
    .wr_clk(clk), .rd_clk(1'b0), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(w_addr), .rd_data(w_data));

  mw_sdpram #(.RATIO(1), .SEP_CLK(1'b1), .HAS_RD_EN(1'b0), .RDW_OLD(1'b0)) u_sep (
    .wr_clk(clk), .rd_clk(rclk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(1'b0), .rd_addr(s_addr), .rd_data(s_data));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] filled(input int a);
    return 8'(255 - a);
  endfunction

  task automatic t_blank();
    @(negedge clk); n_addr = 8'd200; w_addr = 7'd5;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 narrow blank", {8'h0, n_data}, 16'h0);
    chk("R7 wide blank", w_data, 16'h0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 8'(i); wr_data = filled(i);
    end
    @(negedge clk); wr_addr = 8'd255; wr_data = 8'h5A;
    @(negedge clk); wr_addr = 8'd254; wr_data = 8'hA5;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_narrow_stream();
    for (int k = 0; k < 18; k++) begin
      @(negedge clk);
      if (k >= 2) chk("R2 R4 narrow stream", {8'h0, n_data}, {8'h0, filled(k - 2)});
      if (k < 16) n_addr = 8'(k);
    end
    @(negedge clk); n_addr = 8'd255;
    @(negedge clk);
    chk("R4 not after one edge", {8'h0, n_data}, {8'h0, filled(15)});
    @(negedge clk);
    chk("R1 R4 top byte after two edges", {8'h0, n_data}, 16'h005A);
  endtask

  task automatic t_wide();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) chk("R3 wide packing", w_data, {filled(2*(k-2)+1), filled(2*(k-2))});
      if (k < 8) w_addr = 7'(k);
    end
    @(negedge clk); w_addr = 7'd127;
    repeat (2) @(negedge clk);
    chk("R3 wide top word", w_data, 16'h5AA5);
  endtask

  task automatic t_hold();
    @(negedge clk); n_addr = 8'd3;
    repeat (2) @(negedge clk);
    chk("R5 before disable", {8'h0, n_data}, {8'h0, filled(3)});
    rd_en = 1'b0; n_addr = 8'd7;
    repeat (4) @(negedge clk);
    chk("R5 held while disabled", {8'h0, n_data}, {8'h0, filled(3)});
    rd_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 resumes", {8'h0, n_data}, {8'h0, filled(7)});
  endtask

  task automatic t_no_write();
    @(negedge clk); wr_en = 1'b0; wr_addr = 8'd5; wr_data = 8'h11; n_addr = 8'd5;
    repeat (4) @(negedge clk);
    chk("R8 disabled write ignored", {8'h0, n_data}, {8'h0, filled(5)});
  endtask

  task automatic t_collision();
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'd20; wr_data = 8'hC3; n_addr = 8'd20;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    chk("R6 old data on collision", {8'h0, n_data}, 16'h0000);
    @(negedge clk);
    chk("R6 new data afterwards", {8'h0, n_data}, 16'h00C3);
  endtask

  task automatic t_concurrent();
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'd30; wr_data = 8'h77; n_addr = 8'd4;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    chk("R10 read beside write", {8'h0, n_data}, {8'h0, filled(4)});
    n_addr = 8'd30;
    repeat (2) @(negedge clk);
    chk("R10 write beside read stored", {8'h0, n_data}, 16'h0077);
  endtask

  task automatic t_sep();
    for (int i = 0; i < 16; i += 5) begin
      @(negedge rclk); s_addr = 8'(i);
      repeat (2) @(posedge rclk);
      @(negedge rclk);
      chk("R9 separate read clock", {8'h0, s_data}, {8'h0, filled(i)});
    end
    @(negedge rclk); s_addr = 8'd255;
    repeat (2) @(posedge rclk);
    @(negedge rclk);
    chk("R9 separate top byte", {8'h0, s_data}, 16'h005A);
  endtask

  initial begin
    t_blank();
    t_fill();
    t_narrow_stream();
    t_wide();
    t_hold();
    t_no_write();
    t_collision();
    t_concurrent();
    t_sep();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule